// File: doc/BRIEF.md
# MII Management Serial Master

This block runs clause-22 style register transactions against one or more PHYs over the two-wire management interface. A host presents a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data, then pulses a start strobe while the block is idle. The block produces the management clock from its system clock through a programmable divider. It then generates the whole frame in hardware: preamble, start delimiter, opcode, both addresses, turnaround, data and a closing idle clock. The shared bidirectional data line is split into a driven value, a sampled input and an output enable, so the pad can sit outside this block.

A one-cycle done pulse marks the end of each transaction. At that point the read data and a no-acknowledge flag are valid, and they hold until the next start. If a PHY does not answer a read, the block still clocks through the full data phase and the closing cycle, so every PHY on the bus stays aligned with the frame.

The sequencer moves through these states. S_IDLE goes to S_PREAMBLE on an accepted start. S_PREAMBLE (32 periods) goes to S_HEADER (14 periods). S_HEADER goes to S_WR_TA for a write or to S_RD_TA for a read. The write path is S_WR_TA (2 periods), then S_WR_DATA (16), then S_WR_IDLE (1), then S_DONE. The read path is S_RD_TA (2), then S_RD_DATA (16), then S_RD_TRAIL (1), then S_DONE. S_DONE lasts one system cycle and returns to S_IDLE. Each timed state changes on the falling-edge event of the management clock in its last period.

Top module: `mdio_master`

## Requirements
- R1: After reset and while idle, mdc is low, mdio_oe is low, req_busy is low and rsp_done is low.
- R2: Each transaction opens with 32 management clock periods in which mdio_oe is high and mdio_out is high.
- R3: The preamble is followed by the start delimiter 0 then 1, and then the opcode: 1,0 for a read (req_write=0) and 0,1 for a write (req_write=1), each bit held for one period.
- R4: After the opcode, the 5-bit PHY address and then the 5-bit register address are sent MSB first, one bit per period, with mdio_oe high.
- R5: On a write, the block then drives the turnaround bits 1,0, the 16 data bits MSB first and one further period with mdio_oe high and mdio_out high, and afterwards mdio_oe goes low.
- R6: On a read, mdio_oe is low in every period after the register address. mdio_in is sampled in the second turnaround period, and a low level there counts as an acknowledge.
- R7: An acknowledged read returns on rsp_rdata the 16 bits sampled from mdio_in, MSB first, one per period, with rsp_nack low.
- R8: An unacknowledged read still runs all 16 data periods and the closing period. It then reports rsp_nack high and rsp_rdata equal to zero.
- R9: Reads and writes both take exactly 65 management clock periods. rsp_done rises in the system cycle in which the 65th period ends.
- R10: A management clock period is 2*HALF_CNT system cycles, starting low. mdio_out and mdio_oe change only at falling edges or at start, never at a rising edge.
- R11: req_busy is high from the accepted start until rsp_done. rsp_done lasts exactly one cycle. A start strobe, or a change of request fields, while busy has no effect on the frame in progress and causes no second transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Start strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| req_busy | output | 1 | Transaction in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data (zero for writes and unacknowledged reads) |
| rsp_nack | output | 1 | Read was not acknowledged |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Value driven onto the data line |
| mdio_in | input | 1 | Value sampled from the data line |
| mdio_oe | output | 1 | Drive enable for the data line |

## Verification
The assertions assume that mdio_in is already synchronous to the system clock and steady over the cycle before each rising-edge event. They also assume that the start strobe and the request fields are valid in the cycle in which the strobe is high. The bench plays the PHY: it changes mdio_in only right after a falling management clock edge, which leaves at least HALF_CNT cycles before the sampling point. It raises the strobe for exactly one cycle. Its one mid-frame strobe, which also carries altered fields, falls while the clock is high and away from any sampling event.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_PREAMBLE,
        S_HEADER,
        S_WR_TA,
        S_WR_DATA,
        S_WR_IDLE,
        S_RD_TA,
        S_RD_DATA,
        S_RD_TRAIL,
        S_DONE
    } mdio_state_t;

    localparam int PRE_LEN  = 32;
    localparam int HDR_LEN  = 14;
    localparam int TA_LEN   = 2;
    localparam int DATA_LEN = 16;
    localparam int ADDR_W   = 5;
    localparam int FRAME_W  = HDR_LEN + TA_LEN + DATA_LEN;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int HALF_CNT = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic mdc_o,
    output logic rise_ev_o,
    output logic fall_ev_o
);
    localparam int CW = (HALF_CNT > 1) ? $clog2(HALF_CNT) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CNT - 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          wrap;

    assign wrap      = run_i && (cnt_q == LAST);
    assign rise_ev_o = wrap && !mdc_q;
    assign fall_ev_o = wrap && mdc_q;
    assign mdc_o     = mdc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run_i) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R10: clock stays low whenever the sequencer is not running a frame
    p_mdc_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !mdc_q);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                write_i,
    input  logic [ADDR_W-1:0]   phy_i,
    input  logic [ADDR_W-1:0]   reg_i,
    input  logic [DATA_LEN-1:0] wdata_i,
    input  logic                rise_ev_i,
    input  logic                fall_ev_i,
    input  logic                mdi_i,
    input  logic                mdc_i,
    output logic                run_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [DATA_LEN-1:0] rdata_o,
    output logic                nack_o,
    output logic                mdo_o,
    output logic                oe_o
);
    localparam int CNT_W = $clog2(PRE_LEN);

    mdio_state_t        state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [FRAME_W-1:0] tx_q;
    logic [DATA_LEN-1:0] rx_q;
    logic               wr_q;
    logic               ack_q;
    logic               last_bit;

    assign last_bit = fall_ev_i && (cnt_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (fall_ev_i && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
        unique case (state_q)
            S_IDLE: if (start_i) begin
                state_d = S_PREAMBLE;
                cnt_d   = CNT_W'(PRE_LEN - 1);
            end
            S_PREAMBLE: if (last_bit) begin
                state_d = S_HEADER;
                cnt_d   = CNT_W'(HDR_LEN - 1);
            end
            S_HEADER: if (last_bit) begin
                state_d = wr_q ? S_WR_TA : S_RD_TA;
                cnt_d   = CNT_W'(TA_LEN - 1);
            end
            S_WR_TA: if (last_bit) begin
                state_d = S_WR_DATA;
                cnt_d   = CNT_W'(DATA_LEN - 1);
            end
            S_WR_DATA: if (last_bit) begin
                state_d = S_WR_IDLE;
                cnt_d   = '0;
            end
            S_WR_IDLE: if (last_bit) state_d = S_DONE;
            S_RD_TA: if (last_bit) begin
                state_d = S_RD_DATA;
                cnt_d   = CNT_W'(DATA_LEN - 1);
            end
            S_RD_DATA: if (last_bit) begin
                state_d = S_RD_TRAIL;
                cnt_d   = '0;
            end
            S_RD_TRAIL: if (last_bit) state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // frame shift and capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q  <= '0;
            rx_q  <= '0;
            wr_q  <= 1'b0;
            ack_q <= 1'b0;
        end else if (state_q == S_IDLE) begin
            if (start_i) begin
                tx_q  <= {2'b01, (write_i ? 2'b01 : 2'b10), phy_i, reg_i, 2'b10, wdata_i};
                wr_q  <= write_i;
                rx_q  <= '0;
                ack_q <= 1'b0;
            end
        end else begin
            if (fall_ev_i && (state_q == S_HEADER || state_q == S_WR_TA ||
                              state_q == S_WR_DATA)) begin
                tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
            end
            if (rise_ev_i && state_q == S_RD_TA && cnt_q == '0) begin
                ack_q <= ~mdi_i;
            end
            if (rise_ev_i && state_q == S_RD_DATA) begin
                rx_q <= {rx_q[DATA_LEN-2:0], mdi_i};
            end
        end
    end

    // outputs
    always_comb begin
        oe_o  = 1'b0;
        mdo_o = 1'b0;
        unique case (state_q)
            S_PREAMBLE, S_WR_IDLE: begin
                oe_o  = 1'b1;
                mdo_o = 1'b1;
            end
            S_HEADER, S_WR_TA, S_WR_DATA: begin
                oe_o  = 1'b1;
                mdo_o = tx_q[FRAME_W-1];
            end
            S_IDLE, S_RD_TA, S_RD_DATA, S_RD_TRAIL, S_DONE: begin
                oe_o  = 1'b0;
                mdo_o = 1'b0;
            end
            default: begin
                oe_o  = 1'b0;
                mdo_o = 1'b0;
            end
        endcase
    end

    assign run_o   = (state_q != S_IDLE) && (state_q != S_DONE);
    assign busy_o  = (state_q != S_IDLE);
    assign done_o  = (state_q == S_DONE);
    assign nack_o  = !wr_q && !ack_q && (state_q == S_IDLE || state_q == S_DONE)
                     && (tx_q != '0);
    assign rdata_o = (wr_q || !ack_q) ? '0 : rx_q;

    // R11: completion lasts one cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R11: busy only falls through a completion
    p_busy_until_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o));
    // R8: an unacknowledged read reports zero data
    p_nack_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && nack_o) |-> (rdata_o == '0));
    // R10: data line outputs never move at a rising clock edge
    p_stable_at_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc_i) |-> ($stable(mdo_o) && $stable(oe_o)));
    // R1: no drive while idle
    p_no_drive_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !oe_o);
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int HALF_CNT = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_start,
    input  logic        req_write,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    output logic        req_busy,
    output logic        rsp_done,
    output logic [15:0] rsp_rdata,
    output logic        rsp_nack,
    output logic        mdc,
    output logic        mdio_out,
    input  logic        mdio_in,
    output logic        mdio_oe
);
    logic run;
    logic rise_ev;
    logic fall_ev;

    mdio_clkdiv #(.HALF_CNT(HALF_CNT)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .mdc_o     (mdc),
        .rise_ev_o (rise_ev),
        .fall_ev_o (fall_ev)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (req_start),
        .write_i   (req_write),
        .phy_i     (req_phy),
        .reg_i     (req_reg),
        .wdata_i   (req_wdata),
        .rise_ev_i (rise_ev),
        .fall_ev_i (fall_ev),
        .mdi_i     (mdio_in),
        .mdc_i     (mdc),
        .run_o     (run),
        .busy_o    (req_busy),
        .done_o    (rsp_done),
        .rdata_o   (rsp_rdata),
        .nack_o    (rsp_nack),
        .mdo_o     (mdio_out),
        .oe_o      (mdio_oe)
    );
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
    localparam int HALF   = 2;
    localparam int NPER   = 65;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        req_busy, rsp_done, rsp_nack, mdc, mdio_out, mdio_oe;
    logic [15:0] rsp_rdata;
    logic        mdio_in = 1'b1;

    int checks = 0;
    int failures = 0;

    logic       rec_oe  [NPER];
    logic       rec_mdo [NPER];
    logic       pat     [NPER+1];
    logic       done_seen;
    logic       busy_seen;
    realtime    t_rise0, t_rise1;

    always #10 clk = ~clk;

    mdio_master #(.HALF_CNT(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .req_busy(req_busy), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .rsp_nack(rsp_nack), .mdc(mdc), .mdio_out(mdio_out), .mdio_in(mdio_in),
        .mdio_oe(mdio_oe)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // runs one frame as the PHY; inject=1 pulses a stray start mid-frame
    task automatic run_txn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input bit ack, input logic [15:0] rd,
                           input bit inject);
        for (int k = 0; k <= NPER; k++) pat[k] = 1'b1;
        if (!wr) begin
            pat[47] = !ack;
            for (int k = 0; k < 16; k++) pat[48+k] = rd[15-k];
        end
        mdio_in = pat[0];
        @(posedge clk); #1;
        req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd; req_start = 1'b1;
        @(posedge clk); #1;
        req_start = 1'b0;
        busy_seen = req_busy;
        for (int k = 0; k < NPER; k++) begin
            @(posedge mdc);
            if (k == 0) t_rise0 = $realtime;
            if (k == 1) t_rise1 = $realtime;
            rec_oe[k]  = mdio_oe;
            rec_mdo[k] = mdio_out;
            if (inject && k == 20) begin
                #1;
                req_start = 1'b1; req_write = !wr; req_phy = ~phy; req_reg = ~rg;
                req_wdata = ~wd;
                @(posedge clk); #1;
                req_start = 1'b0;
            end
            @(negedge mdc);
            mdio_in = pat[k+1];
        end
        #1;
        done_seen = rsp_done;
    endtask

    task automatic check_frame(input bit wr, input logic [4:0] phy,
                               input logic [4:0] rg, input logic [15:0] wd);
        int e2, e3, e4, e5, e6;
        logic [13:0] hdr;
        logic [17:0] tail;
        e2 = 0; e3 = 0; e4 = 0; e5 = 0; e6 = 0;
        hdr  = {2'b01, (wr ? 2'b01 : 2'b10), phy, rg};
        tail = {2'b10, wd};
        for (int k = 0; k < 32; k++) if (!(rec_oe[k] && rec_mdo[k])) e2++;
        for (int k = 0; k < 4; k++)
            if (!(rec_oe[32+k] && rec_mdo[32+k] == hdr[13-k])) e3++;
        for (int k = 4; k < 14; k++)
            if (!(rec_oe[32+k] && rec_mdo[32+k] == hdr[13-k])) e4++;
        if (wr) begin
            for (int k = 0; k < 18; k++)
                if (!(rec_oe[46+k] && rec_mdo[46+k] == tail[17-k])) e5++;
            if (!(rec_oe[64] && rec_mdo[64])) e5++;
            chk(e5 == 0, "R5 write turnaround/data/idle", e5, 0);
        end else begin
            for (int k = 46; k < NPER; k++) if (rec_oe[k]) e6++;
            chk(e6 == 0, "R6 read release", e6, 0);
        end
        chk(e2 == 0, "R2 preamble", e2, 0);
        chk(e3 == 0, "R3 start/opcode", e3, 0);
        chk(e4 == 0, "R4 addresses", e4, 0);
        chk(done_seen, "R9 done after 65th period", done_seen, 1);
        chk(busy_seen, "R11 busy during frame", busy_seen, 1);
        @(posedge clk); #1;
        chk(!rsp_done, "R11 done one cycle", rsp_done, 0);
        chk(!mdio_oe && !mdc, "R5 released after frame", {mdio_oe, mdc}, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk({mdc, mdio_oe, req_busy, rsp_done} == 4'b0, "R1 idle after reset",
            {mdc, mdio_oe, req_busy, rsp_done}, 0);
    endtask

    task automatic t_write(input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd);
        run_txn(1'b1, phy, rg, wd, 1'b1, 16'h0, 1'b0);
        chk(rsp_nack == 1'b0, "R5 write no error", rsp_nack, 0);
        check_frame(1'b1, phy, rg, wd);
        chk((t_rise1 - t_rise0) == 2.0 * HALF * 20.0, "R10 mdc period",
            int'(t_rise1 - t_rise0), 2 * HALF * 20);
    endtask

    task automatic t_read_ack(input logic [4:0] phy, input logic [4:0] rg,
                              input logic [15:0] rd);
        run_txn(1'b0, phy, rg, 16'h0, 1'b1, rd, 1'b0);
        chk(rsp_rdata == rd && !rsp_nack, "R7 read data", {rsp_nack, rsp_rdata},
            {1'b0, rd});
        check_frame(1'b0, phy, rg, 16'h0);
    endtask

    task automatic t_read_nack;
        run_txn(1'b0, 5'h09, 5'h12, 16'h0, 1'b0, 16'hBEEF, 1'b0);
        chk(done_seen, "R8 nack read still 65 periods", done_seen, 1);
        chk(rsp_nack && rsp_rdata == 16'h0, "R8 nack result",
            {rsp_nack, rsp_rdata}, {1'b1, 16'h0});
        check_frame(1'b0, 5'h09, 5'h12, 16'h0);
        chk(rsp_nack && rsp_rdata == 16'h0, "R8 result held", {rsp_nack, rsp_rdata},
            {1'b1, 16'h0});
    endtask

    task automatic t_start_while_busy;
        int extra;
        run_txn(1'b1, 5'h15, 5'h0C, 16'h3C96, 1'b1, 16'h0, 1'b1);
        check_frame(1'b1, 5'h15, 5'h0C, 16'h3C96);
        extra = 0;
        repeat (4 * HALF * 2) begin
            @(posedge clk); #1;
            if (rsp_done || req_busy || mdc) extra++;
        end
        chk(extra == 0, "R11 start while busy ignored", extra, 0);
    endtask

    initial begin
        t_reset();
        t_write(5'h11, 5'h0A, 16'hA55A);
        t_write(5'h00, 5'h1F, 16'h0001);
        t_read_ack(5'h1F, 5'h00, 16'h8001);
        t_read_ack(5'h03, 5'h15, 16'hC3A5);
        t_read_nack();
        t_start_while_busy();
        t_read_ack(5'h01, 5'h02, 16'hFFFE);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule